// File: doc/BRIEF.md
# Dual-Clock Two-Port Read/Write RAM

This block is a parameterized memory reached through two ports that are fully independent of each other. Each port has its own clock, clock enable, write enable, address and write data, and a registered read output. The two clocks need not be related in frequency or in phase. Either port can read or write any of the 2^A_BITS words. Data written through one port can be read through the other once the write has settled.

Each port acts on the rising edge of its own clock. While its enable is low, the port does nothing. With the enable high, the write enable selects a write or a read. A read returns the addressed word in the cycle after the edge. A write stores the word and also puts it on that port's own read output (write-first).

Suppose one port reads the word that the other port is writing. If the read falls between the write edge and the writing clock's next rising edge, the read value is undefined. The stored word is not affected. Each port also has a synchronous reset that clears only its read register and never the stored words.

Top module: `tdp_ram`

## Requirements
- R1: With the enable low, a port's edge does nothing, whatever its write enable is: the read output keeps its value and no word changes.
- R2: With the enable high and the write enable low, the read output shows the word at the port's address after that port's next rising clock edge.
- R3: With the enable high and the write enable high, the write data is stored at the port's address, and a later read through the same port returns it.
- R4: On a write edge, that port's read output takes the write data (write-first), independently on each port.
- R5: The memory holds 2^A_BITS distinct words, and every address up to the highest (all ones) stores its own value.
- R6: A word written through one port reads back correctly through the other port once the write window has ended.
- R7: The two ports run concurrently on unrelated clocks without disturbing each other's reads or writes.
- R8: A read through one port of the address the other port is writing returns an undefined value if it falls in the window from the write edge to the writing clock's next edge. The stored word afterwards equals the last value written.
- R9: A port's reset, sampled on that port's clock edge, clears its read output to all zeros and leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of port A |
| rst_a | input | 1 | Synchronous clear of port A read output |
| en_a | input | 1 | Port A clock enable |
| wr_a | input | 1 | Port A write enable (1 = write, 0 = read) |
| addr_a | input | A_BITS | Port A word address |
| wdata_a | input | D_BITS | Port A write data |
| rdata_a | output | D_BITS | Port A registered read data |
| clk_b | input | 1 | Clock of port B |
| rst_b | input | 1 | Synchronous clear of port B read output |
| en_b | input | 1 | Port B clock enable |
| wr_b | input | 1 | Port B write enable (1 = write, 0 = read) |
| addr_b | input | A_BITS | Port B word address |
| wdata_b | input | D_BITS | Port B write data |
| rdata_b | output | D_BITS | Port B registered read data |

## Verification
The two functions that can meet in one instant are a write on one port and a read of the same word on the other port, possibly at coinciding edges of the two clocks. The bench provokes this on purpose: port A rewrites one address again and again while port B reads that address back to back. It also lets the two meet at random during a long stretch of mixed traffic. Any read that lands inside the writer's one-period window is left out of the comparison. After the collision burst, the stored word must equal the last value written, and every read outside the window is compared with the bench's own memory model on every edge.

// File: rtl/tdp_ram_pkg.sv
package tdp_ram_pkg;

   typedef enum logic [1:0] {
      CMD_IDLE  = 2'd0,
      CMD_READ  = 2'd1,
      CMD_WRITE = 2'd2
   } port_cmd_e;

   // enable gates everything; write enable only chooses the direction
   function automatic port_cmd_e decode_cmd(input logic ce, input logic we);
      if (!ce)
         return CMD_IDLE;
      else if (we)
         return CMD_WRITE;
      else
         return CMD_READ;
   endfunction

endpackage

// File: rtl/tdp_ram_bank.sv
// One storage bank with a single write port and two asynchronous lookups.
module tdp_ram_bank #(
   parameter int A_BITS = 5,
   parameter int D_BITS = 16
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [A_BITS-1:0] wr_addr,
   input  logic [D_BITS-1:0] wr_data,
   input  logic [A_BITS-1:0] look0_addr,
   output logic [D_BITS-1:0] look0_data,
   input  logic [A_BITS-1:0] look1_addr,
   output logic [D_BITS-1:0] look1_data
);
   localparam int DEPTH = 1 << A_BITS;

   logic [D_BITS-1:0] cells [DEPTH];

   // power-up contents: both banks zero, so their XOR reads as zero
   initial begin
      for (int i = 0; i < DEPTH; i++) cells[i] = '0;
   end

   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_addr] <= wr_data;
   end

   assign look0_data = cells[look0_addr];
   assign look1_data = cells[look1_addr];

endmodule

// File: rtl/tdp_ram_port.sv
// Command decode and registered read output for one port.
module tdp_ram_port
   import tdp_ram_pkg::*;
#(
   parameter int D_BITS = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce,
   input  logic              we,
   input  logic [D_BITS-1:0] din,
   input  logic [D_BITS-1:0] own_word,   // own bank at this port's address
   input  logic [D_BITS-1:0] peer_word,  // other bank at this port's address
   output logic              bank_we,
   output logic [D_BITS-1:0] bank_wdata,
   output logic [D_BITS-1:0] q
);
   port_cmd_e cmd;

   assign cmd        = decode_cmd(ce, we);
   assign bank_we    = (cmd == CMD_WRITE);
   // store din XOR peer so that own ^ peer later yields din
   assign bank_wdata = din ^ peer_word;

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else begin
         unique case (cmd)
            CMD_WRITE: q <= din;
            CMD_READ:  q <= own_word ^ peer_word;
            default:   q <= q;
         endcase
      end
   end

endmodule

// File: rtl/tdp_ram.sv
module tdp_ram #(
   parameter int A_BITS = 5,
   parameter int D_BITS = 16
) (
   input  logic              clk_a,
   input  logic              rst_a,
   input  logic              en_a,
   input  logic              wr_a,
   input  logic [A_BITS-1:0] addr_a,
   input  logic [D_BITS-1:0] wdata_a,
   output logic [D_BITS-1:0] rdata_a,
   input  logic              clk_b,
   input  logic              rst_b,
   input  logic              en_b,
   input  logic              wr_b,
   input  logic [A_BITS-1:0] addr_b,
   input  logic [D_BITS-1:0] wdata_b,
   output logic [D_BITS-1:0] rdata_b
);
   localparam int NPORTS = 2;

   if (A_BITS < 1 || A_BITS > 20) begin : g_bad_abits
      $error("tdp_ram: A_BITS must lie in 1..20");
   end
   if (D_BITS < 1) begin : g_bad_dbits
      $error("tdp_ram: D_BITS must be positive");
   end

   logic              clk_v   [NPORTS];
   logic              rst_v   [NPORTS];
   logic              ce_v    [NPORTS];
   logic              we_v    [NPORTS];
   logic [A_BITS-1:0] addr_v  [NPORTS];
   logic [D_BITS-1:0] din_v   [NPORTS];
   logic [D_BITS-1:0] q_v     [NPORTS];
   logic              bwe_v   [NPORTS];
   logic [D_BITS-1:0] bwd_v   [NPORTS];
   logic [D_BITS-1:0] at_own  [NPORTS];  // bank p at port p's address
   logic [D_BITS-1:0] at_peer [NPORTS];  // bank p at the other port's address

   assign clk_v[0]  = clk_a;   assign clk_v[1]  = clk_b;
   assign rst_v[0]  = rst_a;   assign rst_v[1]  = rst_b;
   assign ce_v[0]   = en_a;    assign ce_v[1]   = en_b;
   assign we_v[0]   = wr_a;    assign we_v[1]   = wr_b;
   assign addr_v[0] = addr_a;  assign addr_v[1] = addr_b;
   assign din_v[0]  = wdata_a; assign din_v[1]  = wdata_b;
   assign rdata_a   = q_v[0];
   assign rdata_b   = q_v[1];

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      localparam int O = NPORTS - 1 - p;

      tdp_ram_bank #(
         .A_BITS (A_BITS),
         .D_BITS (D_BITS)
      ) u_bank (
         .clk        (clk_v[p]),
         .wr_en      (bwe_v[p]),
         .wr_addr    (addr_v[p]),
         .wr_data    (bwd_v[p]),
         .look0_addr (addr_v[p]),
         .look0_data (at_own[p]),
         .look1_addr (addr_v[O]),
         .look1_data (at_peer[p])
      );

      tdp_ram_port #(
         .D_BITS (D_BITS)
      ) u_ctrl (
         .clk        (clk_v[p]),
         .rst        (rst_v[p]),
         .ce         (ce_v[p]),
         .we         (we_v[p]),
         .din        (din_v[p]),
         .own_word   (at_own[p]),
         .peer_word  (at_peer[O]),
         .bank_we    (bwe_v[p]),
         .bank_wdata (bwd_v[p]),
         .q          (q_v[p])
      );
   end

endmodule

// File: rtl/tdp_ram_chk.sv
module tdp_ram_chk #(
   parameter int A_BITS = 5,
   parameter int D_BITS = 16
) (
   input logic              clk_a,
   input logic              rst_a,
   input logic              en_a,
   input logic              wr_a,
   input logic [A_BITS-1:0] addr_a,
   input logic [D_BITS-1:0] wdata_a,
   input logic [D_BITS-1:0] rdata_a,
   input logic              clk_b,
   input logic              rst_b,
   input logic              en_b,
   input logic              wr_b,
   input logic [A_BITS-1:0] addr_b,
   input logic [D_BITS-1:0] wdata_b,
   input logic [D_BITS-1:0] rdata_b
);
   // idle edge leaves the read register alone
   assert_idle_hold_a_R1: assert property (@(posedge clk_a) disable iff (rst_a)
      (!$past(en_a) && !$past(rst_a)) |-> $stable(rdata_a));
   assert_idle_hold_b_R1: assert property (@(posedge clk_b) disable iff (rst_b)
      (!$past(en_b) && !$past(rst_b)) |-> $stable(rdata_b));

   // write-first on each port
   assert_write_first_a_R4: assert property (@(posedge clk_a) disable iff (rst_a)
      $past(en_a && wr_a && !rst_a) |-> (rdata_a == $past(wdata_a)));
   assert_write_first_b_R4: assert property (@(posedge clk_b) disable iff (rst_b)
      $past(en_b && wr_b && !rst_b) |-> (rdata_b == $past(wdata_b)));

   // reset clears the read register
   assert_reset_clear_a_R9: assert property (@(posedge clk_a)
      rst_a |=> (rdata_a == '0));
   assert_reset_clear_b_R9: assert property (@(posedge clk_b)
      rst_b |=> (rdata_b == '0));

   wire unused_ok = ^{addr_a, addr_b};

endmodule

bind tdp_ram tdp_ram_chk #(
   .A_BITS (A_BITS),
   .D_BITS (D_BITS)
) u_chk (
   .clk_a   (clk_a),
   .rst_a   (rst_a),
   .en_a    (en_a),
   .wr_a    (wr_a),
   .addr_a  (addr_a),
   .wdata_a (wdata_a),
   .rdata_a (rdata_a),
   .clk_b   (clk_b),
   .rst_b   (rst_b),
   .en_b    (en_b),
   .wr_b    (wr_b),
   .addr_b  (addr_b),
   .wdata_b (wdata_b),
   .rdata_b (rdata_b)
);

// File: tb/tdp_ram_test.sv
module tdp_ram_test;
   localparam int  AW         = 5;
   localparam int  DW         = 16;
   localparam int  DEPTH      = 1 << AW;
   localparam int  HALF       = DEPTH / 2;
   localparam int  CLK_PERIOD = 10;
   localparam int  PER_B      = 14;
   localparam int  NRAND      = 300;

   logic          clk_a = 1'b0, clk_b = 1'b0;
   logic          rst_a = 1'b1, rst_b = 1'b1;
   logic          en_a = 1'b0, en_b = 1'b0;
   logic          wr_a = 1'b0, wr_b = 1'b0;
   logic [AW-1:0] addr_a = '0, addr_b = '0;
   logic [DW-1:0] wdata_a = '0, wdata_b = '0;
   logic [DW-1:0] rdata_a, rdata_b;

   always #(CLK_PERIOD/2) clk_a = ~clk_a;
   always #(PER_B/2)      clk_b = ~clk_b;

   tdp_ram #(.A_BITS(AW), .D_BITS(DW)) uut (
      .clk_a(clk_a), .rst_a(rst_a), .en_a(en_a), .wr_a(wr_a),
      .addr_a(addr_a), .wdata_a(wdata_a), .rdata_a(rdata_a),
      .clk_b(clk_b), .rst_b(rst_b), .en_b(en_b), .wr_b(wr_b),
      .addr_b(addr_b), .wdata_b(wdata_b), .rdata_b(rdata_b));

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit good, input string req, input string what,
                      input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_chk++;
      if (!good) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // ---------------- behavioural reference ----------------
   logic [DW-1:0] ref_mem [DEPTH];
   bit            ref_ok  [DEPTH];
   longint        wt_a    [DEPTH];
   longint        wt_b    [DEPTH];
   logic [DW-1:0] exp_a = '0, exp_b = '0;
   bit            ok_a = 0, ok_b = 0;
   string         tag_a = "R9", tag_b = "R9";
   string         phase_a = "R4", phase_b = "R4";

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         ref_ok[i] = 0; wt_a[i] = -1; wt_b[i] = -1; ref_mem[i] = '0;
      end
   end

   always @(posedge clk_a) begin
      if (rst_a) begin
         exp_a = '0; ok_a = 1; tag_a = "R9";
      end else if (en_a && wr_a) begin
         ref_mem[addr_a] = wdata_a; ref_ok[addr_a] = 1; wt_a[addr_a] = $time;
         exp_a = wdata_a; ok_a = 1; tag_a = "R4";
      end else if (en_a) begin
         // skip reads that fall inside port B's write window (R8)
         ok_a = ref_ok[addr_a] &&
                !(wt_b[addr_a] >= 0 && ($time - wt_b[addr_a]) < PER_B);
         exp_a = ref_mem[addr_a];
         if (addr_a == DEPTH-1)                     tag_a = "R5";
         else if (phase_a == "R2" && addr_a >= HALF) tag_a = "R6";
         else                                        tag_a = phase_a;
      end else begin
         tag_a = "R1";
      end
   end

   always @(posedge clk_b) begin
      if (rst_b) begin
         exp_b = '0; ok_b = 1; tag_b = "R9";
      end else if (en_b && wr_b) begin
         ref_mem[addr_b] = wdata_b; ref_ok[addr_b] = 1; wt_b[addr_b] = $time;
         exp_b = wdata_b; ok_b = 1; tag_b = "R4";
      end else if (en_b) begin
         ok_b = ref_ok[addr_b] &&
                !(wt_a[addr_b] >= 0 && ($time - wt_a[addr_b]) < CLK_PERIOD);
         exp_b = ref_mem[addr_b];
         if (addr_b == DEPTH-1)                     tag_b = "R5";
         else if (phase_b == "R2" && addr_b < HALF)  tag_b = "R6";
         else                                        tag_b = phase_b;
      end else begin
         tag_b = "R1";
      end
   end

   // compare on every falling edge, half a cycle after the register updated
   always @(negedge clk_a) if (ok_a) chk(rdata_a === exp_a, tag_a, "port A", rdata_a, exp_a);
   always @(negedge clk_b) if (ok_b) chk(rdata_b === exp_b, tag_b, "port B", rdata_b, exp_b);

   // ---------------- stimulus ----------------
   task automatic op_a(input bit ce, input bit we, input int adr, input logic [DW-1:0] d);
      @(negedge clk_a);
      en_a = ce; wr_a = we; addr_a = AW'(adr); wdata_a = d;
   endtask

   task automatic op_b(input bit ce, input bit we, input int adr, input logic [DW-1:0] d);
      @(negedge clk_b);
      en_b = ce; wr_b = we; addr_b = AW'(adr); wdata_b = d;
   endtask

   bit init_a_done = 0, init_b_done = 0;
   bit coll_a_ready = 0, coll_b_ready = 0, coll_a_done = 0;

   task automatic run_a();
      repeat (3) @(negedge clk_a);
      rst_a = 1'b0;
      phase_a = "R4";
      for (int i = 0; i < HALF; i++) op_a(1, 1, i, DW'(16'hA000 + i));
      op_a(0, 0, 0, '0);
      init_a_done = 1;
      wait (init_b_done);
      phase_a = "R2";
      for (int i = 0; i < DEPTH; i++) op_a(1, 0, i, '0);
      // R1: enable low with write enable high changes nothing
      phase_a = "R1";
      op_a(1, 0, 7, '0);
      for (int k = 0; k < 4; k++) op_a(0, 1, 2, 16'hDEAD);
      op_a(1, 0, 2, '0);
      op_a(0, 0, 0, '0);
      // R3: overwrite then read back through the same port
      phase_a = "R3";
      op_a(1, 1, 3, 16'h1234);
      op_a(1, 0, 9, '0);
      op_a(1, 0, 3, '0);
      op_a(0, 0, 0, '0);
      // R8: hammer one address while port B reads it
      coll_a_ready = 1;
      wait (coll_b_ready);
      for (int k = 0; k <= 5; k++) op_a(1, 1, 5, DW'(16'h5500 + k));
      op_a(0, 0, 0, '0);
      op_a(0, 0, 0, '0);
      coll_a_done = 1;
      // R7: random concurrent traffic, writes kept to the lower half
      phase_a = "R7";
      for (int k = 0; k < NRAND; k++) begin
         automatic bit ce = ($urandom % 4) != 0;
         automatic bit we = $urandom % 2;
         automatic int ad = we ? int'($urandom % HALF) : int'($urandom % DEPTH);
         op_a(ce, we, ad, DW'($urandom));
      end
      // R9: reset clears the output but not the memory
      op_a(0, 0, 0, '0);
      @(negedge clk_a); rst_a = 1'b1;
      @(negedge clk_a); rst_a = 1'b0;
      phase_a = "R9";
      op_a(1, 0, 3, '0);
      op_a(1, 0, HALF + 1, '0);
      op_a(0, 0, 0, '0);
      repeat (2) @(negedge clk_a);
   endtask

   task automatic run_b();
      repeat (3) @(negedge clk_b);
      rst_b = 1'b0;
      phase_b = "R4";
      for (int i = HALF; i < DEPTH; i++) op_b(1, 1, i, DW'(16'hB000 + i));
      op_b(0, 0, 0, '0);
      init_b_done = 1;
      wait (init_a_done);
      phase_b = "R2";
      for (int i = DEPTH - 1; i >= 0; i--) op_b(1, 0, i, '0);
      phase_b = "R1";
      op_b(1, 0, HALF + 4, '0);
      for (int k = 0; k < 3; k++) op_b(0, 1, HALF + 2, 16'hBEEF);
      op_b(1, 0, HALF + 2, '0);
      op_b(0, 0, 0, '0);
      phase_b = "R3";
      op_b(1, 1, HALF + 6, 16'h4321);
      op_b(1, 0, HALF + 6, '0);
      op_b(0, 0, 0, '0);
      coll_b_ready = 1;
      wait (coll_a_ready);
      phase_b = "R8";
      for (int k = 0; k < 40 && !coll_a_done; k++) op_b(1, 0, 5, '0);
      op_b(1, 0, 5, '0);
      op_b(0, 0, 0, '0);
      // R8: after the burst the stored word is the last one written
      chk(rdata_b === 16'h5505, "R8", "word after collision", rdata_b, 16'h5505);
      phase_b = "R7";
      for (int k = 0; k < NRAND; k++) begin
         automatic bit ce = ($urandom % 4) != 0;
         automatic bit we = $urandom % 2;
         automatic int ad = we ? int'(HALF + $urandom % HALF) : int'($urandom % DEPTH);
         op_b(ce, we, ad, DW'($urandom));
      end
      op_b(0, 0, 0, '0);
      @(negedge clk_b); rst_b = 1'b1;
      @(negedge clk_b); rst_b = 1'b0;
      phase_b = "R9";
      op_b(1, 0, 3, '0);
      op_b(0, 0, 0, '0);
      repeat (2) @(negedge clk_b);
   endtask

   initial begin
      fork
         run_a();
         run_b();
      join
      summary();
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog: got %0d expected %0d", 1, 0);
      summary();
      $finish;
   end

endmodule